// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block runs one read of a 10-bit serial analog-to-digital converter from the host side. When it takes a start request it pulls chip select low and produces a serial clock by dividing the system clock. On that clock it sends a four-bit configuration header to the converter. It then shifts in the reply and returns the conversion result as one 16-bit word, together with a single-cycle done pulse.

The header goes out first bit first, and always in the same order: a start bit of 1, the single-ended/differential select, the odd/sign select, and a dummy 0. The converter answers with two null bits and then ten result bits, most significant first. A frame is sixteen serial clocks long. The controller ignores the bits sampled during the header and during the two null slots. The result can be returned right-justified (upper pad bits zero) or left-justified (lower pad bits zero).

The block supports two wiring options. With separate data lines, the host output stays driven for the whole frame. With one shared bidirectional line, the host lets go of the line on the fourth rising serial clock edge, before the converter takes the line on the fourth falling edge. The `mosi_oe` output tells the external pad when the host drives. The configuration and the divide setting are captured when a start request is accepted. Start requests that arrive during a frame are ignored.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `mosi_oe`=1 and `result`=0.
- R2: A start request taken while idle drives `cs_n` low and `busy` high one clock later, with `sclk` low. Every change of `sclk`, and the final rise of `cs_n`, comes `clk_div`+1 system clocks after the previous event, counting from the fall of `cs_n`.
- R3: At rising `sclk` edges 1 to 4, `mosi` carries 1, then `sgl_diff`, then `odd_sign`, then 0. `mosi` changes only while `sclk` is low.
- R4: A frame has exactly 16 rising `sclk` edges. `adc_dout` is sampled at rising edges 7 to 16 as result bits B9 down to B0.
- R5: `cs_n` rises on the falling `sclk` edge that follows the 16th rising edge. In that same cycle `done` is high for one clock, `busy` goes low, and `result` is updated.
- R6: With `left_just`=0, `result` = {6'b0, B9..B0}.
- R7: With `left_just`=1, `result` = {B9..B0, 6'b0}.
- R8: With `shared_line`=1, `mosi_oe` goes low in the same cycle as the 4th rising `sclk` edge and stays low until `cs_n` rises. With `shared_line`=0, `mosi_oe` stays 1.
- R9: A start request, or a change of the configuration inputs, while `busy` is high has no effect on the frame in progress or on its result.
- R10: Values on `adc_dout` at rising edges 1 to 6 have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only while idle |
| sgl_diff | input | 1 | Single-ended/differential select sent in the header |
| odd_sign | input | 1 | Odd/sign select sent in the header |
| left_just | input | 1 | 1 = left-justified result, 0 = right-justified |
| shared_line | input | 1 | 1 = one shared bidirectional data line |
| clk_div | input | DIV_W | Serial half-period, in system clocks, minus one |
| adc_dout | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| mosi_oe | output | 1 | Host drive enable for the data line |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| result | output | OUT_W | Packed conversion result |

## Verification
`cs_n` and `busy` respond one system clock after a start is taken. After that, every serial clock edge and the final rise of `cs_n` arrive exactly `clk_div`+1 clocks apart. So `done` and `result` appear 32·(`clk_div`+1) clocks after chip select falls. The bench samples all outputs on the falling system clock edge. It counts clocks between observed events and compares each gap with `clk_div`+1. It checks `done`, `busy`, `cs_n` and `result` in the cycle where `done` is seen, and checks that the pulse has ended one clock later. A converter model reacts to the observed serial clock edges. The bench sweeps divide settings 0 to 2, all sixteen configuration combinations and several result patterns.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    // header is start, sgl/diff, odd/sign, dummy
    parameter int HDR_BITS  = 4;
    // zero bits returned by the converter ahead of the MSB
    parameter int NULL_BITS = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic sgl;
        logic odd;
        logic left;
        logic shared;
    } cfg_t;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == limit);
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt_q <= limit); // R2
endmodule

// File: rtl/adc_rd_pack.sv
module adc_rd_pack #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic [RES_W-1:0] raw,
    input  logic             left,
    output logic [OUT_W-1:0] word_o
);
    localparam int PAD = OUT_W - RES_W;

    generate
        if (PAD > 0) begin : g_pad
            always_comb begin
                if (left)
                    word_o = {raw, {PAD{1'b0}}};
                else
                    word_o = {{PAD{1'b0}}, raw};
            end
        end else begin : g_flat
            logic unused_left;
            assign unused_left = left;
            assign word_o = raw[RES_W-1 -: OUT_W];
        end
    endgenerate
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sgl_diff,
    input  logic             odd_sign,
    input  logic             left_just,
    input  logic             shared_line,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             adc_dout,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             mosi_oe,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] result
);
    localparam int FRAME_RISES = HDR_BITS + NULL_BITS + RES_W;
    localparam int CNT_W       = $clog2(FRAME_RISES + 1);
    localparam int FIRST_CAP   = HDR_BITS + NULL_BITS + 1;

    typedef struct packed {
        phase_e             state;
        logic               cs_n;
        logic               sclk;
        logic               mosi;
        logic               oe;
        logic               busy;
        logic               done;
        logic [CNT_W-1:0]   rises;
        logic [RES_W-1:0]   shreg;
        logic [OUT_W-1:0]   result;
        cfg_t               cfg;
        logic [DIV_W-1:0]   div;
    } regs_t;

    regs_t d, q;
    logic tick;
    logic start_take;
    logic [OUT_W-1:0] word;
    logic [HDR_BITS-1:0] hdr_word;
    logic [HDR_BITS-1:0] hdr_sh;
    logic [CNT_W-1:0] rise_nx;

    assign start_take = (q.state == PH_IDLE) && start;

    adc_rd_clkdiv #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_take),
        .en    (q.state == PH_RUN),
        .limit (q.div),
        .tick  (tick)
    );

    adc_rd_pack #(.RES_W(RES_W), .OUT_W(OUT_W)) u_pack (
        .raw    (q.shreg),
        .left   (q.cfg.left),
        .word_o (word)
    );

    // bit 0 leaves first
    assign hdr_word = {1'b0, q.cfg.odd, q.cfg.sgl, 1'b1};
    assign hdr_sh   = hdr_word >> q.rises;
    assign rise_nx  = q.rises + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            PH_IDLE: begin
                if (start) begin
                    d.state      = PH_RUN;
                    d.cs_n       = 1'b0;
                    d.busy       = 1'b1;
                    d.sclk       = 1'b0;
                    d.mosi       = 1'b1;
                    d.oe         = 1'b1;
                    d.rises      = '0;
                    d.cfg.sgl    = sgl_diff;
                    d.cfg.odd    = odd_sign;
                    d.cfg.left   = left_just;
                    d.cfg.shared = shared_line;
                    d.div        = clk_div;
                end
            end
            default: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk  = 1'b1;
                        d.rises = rise_nx;
                        if (rise_nx >= CNT_W'(FIRST_CAP))
                            d.shreg = {q.shreg[RES_W-2:0], adc_dout};
                        if (q.cfg.shared && rise_nx == CNT_W'(HDR_BITS))
                            d.oe = 1'b0;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.rises == CNT_W'(FRAME_RISES)) begin
                            d.state  = PH_IDLE;
                            d.cs_n   = 1'b1;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                            d.oe     = 1'b1;
                            d.mosi   = 1'b0;
                            d.result = word;
                        end else if (q.rises < CNT_W'(HDR_BITS)) begin
                            d.mosi = hdr_sh[0];
                        end else begin
                            d.mosi = 1'b0;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
            q.oe   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n    = q.cs_n;
    assign sclk    = q.sclk;
    assign mosi    = q.mosi;
    assign mosi_oe = q.oe;
    assign busy    = q.busy;
    assign done    = q.done;
    assign result  = q.result;

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sclk) |-> !$past(q.cs_n)); // R2
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mosi) |-> !q.sclk); // R3
    AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.rises <= CNT_W'(FRAME_RISES)); // R4
    AST_CS_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |-> q.done && !q.sclk && !q.busy); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R5
    AST_RJ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && !q.cfg.left |-> q.result[OUT_W-1:RES_W] == '0); // R6
    AST_SHARED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cfg.shared && $rose(q.sclk) && q.rises == CNT_W'(HDR_BITS) |-> !q.oe); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && start |=> $stable(q.cfg) && $stable(q.div)); // R9
endmodule

// File: tb/adc_read_ctrl_test.sv
module adc_read_ctrl_test;
    // time unit is 1 ps: 5000 ps period gives 200 MHz
    localparam int HALF = 2500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, sgl = 1'b0, odd = 1'b0, left = 1'b0, shared = 1'b0;
    logic [7:0] divs = '0;
    logic adc_dout = 1'b1;
    logic cs_n, sclk, mosi, mosi_oe, busy, done;
    logic [15:0] result;

    int total = 0;
    int bad = 0;
    int cur_div = 0;
    logic cur_shared = 1'b0;
    logic [9:0] cur_val = '0;
    int rises = 0, falls = 0, ctr = 0, tim_bad = 0, oe_bad = 0;
    logic [3:0] hdr_got = '0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always #HALF clk = ~clk;

    adc_read_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sgl_diff(sgl), .odd_sign(odd),
        .left_just(left), .shared_line(shared), .clk_div(divs), .adc_dout(adc_dout),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .busy(busy),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_bit(input int f);
        if (f < 4) return 1'b1;
        if (f < 6) return 1'b0;
        if (f <= 15) return cur_val[15 - f];
        return 1'b0;
    endfunction

    // converter model and edge timing monitor
    always @(negedge clk) begin
        if (rst_n) begin
            ctr++;
            if (prev_cs && !cs_n) begin
                ctr = 0; rises = 0; falls = 0; adc_dout = 1'b1;
            end else if (!prev_cs && cs_n) begin
                if (ctr != cur_div + 1) tim_bad++;
                if (!mosi_oe) oe_bad++;
            end else if (!cs_n && sclk != prev_sclk) begin
                if (ctr != cur_div + 1) tim_bad++;
                ctr = 0;
                if (sclk) begin
                    rises++;
                    if (rises <= 4) hdr_got[rises-1] = mosi;
                    if (mosi_oe != !(cur_shared && rises >= 4)) oe_bad++;
                end else begin
                    falls++;
                    adc_dout = model_bit(falls);
                end
            end
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    task automatic run_frame(input int dv, input bit s, input bit o, input bit l,
                             input bit sh, input logic [9:0] v, input bit poke);
        int n;
        logic [15:0] exp_res;
        @(negedge clk);
        cur_div = dv; cur_shared = sh; cur_val = v;
        tim_bad = 0; oe_bad = 0; hdr_got = '0;
        sgl = s; odd = o; left = l; shared = sh; divs = 8'(dv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n && busy && !sclk, "R2 frame opens", {cs_n, busy, sclk}, 3'b010);
        if (poke) begin
            repeat (5) @(negedge clk);
            sgl = ~s; odd = ~o; left = ~l; shared = ~sh; divs = 8'(dv + 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        exp_res = l ? {v, 6'b0} : {6'b0, v};
        chk(done, "R5 done seen", 32'(done), 1);
        chk(cs_n && !busy, "R5 cs/busy at done", {cs_n, busy}, 2'b10);
        if (l) chk(result == exp_res, "R7 left result R10", result, exp_res);
        else   chk(result == exp_res, "R6 right result R10", result, exp_res);
        if (poke) chk(result == exp_res, "R9 poke ignored", result, exp_res);
        @(negedge clk);
        chk(!done, "R5 done one cycle", 32'(done), 0);
        chk(rises == 16, "R4 rise count", rises, 16);
        chk(hdr_got == {1'b0, o, s, 1'b1}, "R3 header", hdr_got, {1'b0, o, s, 1'b1});
        chk(tim_bad == 0, "R2 edge spacing", tim_bad, 0);
        chk(oe_bad == 0, "R8 drive enable", oe_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !busy && !done && mosi_oe && result == 0, "R1 reset state",
            {cs_n, sclk, busy, done, mosi_oe}, 5'b10001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 2'b10);
        for (int dv = 0; dv < 3; dv++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [9:0] v;
                    if (k == 0) v = '0;
                    else if (k == 1) v = 10'h3FF;
                    else v = 10'((k * 677 + 585) & 1023);
                    run_frame(dv, c[0], c[1], c[2], c[3], v, k == 2);
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule